// File: doc/BRIEF.md
# Per-Core Dependence Register Unit

This unit sits next to one core's second-level cache controller and records, for the checkpoint interval in progress, which processors this core has exchanged data with. A producer bitmap has one bit per processor: bit i is set when this core consumed data that processor i wrote. A consumer bitmap is the converse: bit i is set when processor i consumed data that this core wrote. A Bloom-filter write signature summarises every line address the core wrote, or read with exclusive ownership, during the interval. The directory queries this signature to find out whether its recorded last writer for a line is still current. A miss means that record is stale for this interval.

The unit keeps two complete banks, each with both bitmaps and a signature. A checkpoint command swaps the roles of the banks. The bank that was recording becomes the retired bank and keeps its contents, so dependences on data still waiting for delayed writeback are not lost. The other bank records the new interval. The retired bank is cleared when software reports that the delayed writebacks have finished. A rollback clears both banks. A read port lets software fetch both bitmaps of either bank.

Top module: `dep_reg_unit`

## Requirements
- R1: After reset both banks are empty: both bitmaps read 0 and every signature query misses. `active_set` is 0 and `draining` is 0.
- R2: A `prod_vld` pulse with `prod_old`=0 sets bit `prod_id` of the active bank's producer bitmap. With `prod_old`=1 it sets the bit in the retired bank, but only while `draining` is 1. When `draining` is 0 it has no effect. The bit is visible one cycle later.
- R3: A `cons_vld` pulse sets bit `cons_id` of a consumer bitmap. Bank selection through `cons_old` follows the same rule as R2.
- R4: Bitmap bits and signature bits accumulate by OR. Only a clear (R7, R8) removes them.
- R5: A `wr_vld` pulse inserts `wr_addr` into the active bank's signature. Insertion sets bits h0 and h1 of a 512-bit vector. Split the address, zero-extended to 36 bits, into four 9-bit chunks c0..c3, with c0 at the low end. Then h0 = c0^c1^c2^c3 and h1 is the XOR over k of ck rotated left by 2k+1 bits. `q_hit` is 1 exactly when both bits of `q_addr` are set in the active bank (`q_old`=0) or in the retired bank (`q_old`=1). An inserted address therefore always hits from the next cycle on.
- R6: `ckpt` is accepted when `draining` is 0, or when `wb_done` is asserted in the same cycle. On acceptance, `active_set` toggles and `draining` becomes 1, and the bank that was active keeps its contents as the retired bank. A `ckpt` while draining, without `wb_done`, leaves `active_set` and both banks unchanged. A newly active bank always starts empty.
- R7: `wb_done` while `draining` is 1 clears the retired bank completely and drops `draining`. It beats a same-cycle `prod_old`/`cons_old` update of that bank. The active bank is untouched.
- R8: `rollback` clears both banks and drops `draining`, keeping `active_set`. Updates, inserts, `ckpt` and `wb_done` in the same cycle are discarded.
- R9: `rd_prod`/`rd_cons` show, without delay, the bitmaps of the bank whose absolute index is `rd_sel`.
- R10: An update or insert in the same cycle as an accepted `ckpt` lands in the bank that was active before the checkpoint, which then becomes the retired bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_vld | input | 1 | Record a producer dependence |
| prod_id | input | 4 | Processor that produced the consumed data |
| prod_old | input | 1 | Dependence concerns delayed data of the retired interval |
| cons_vld | input | 1 | Record a consumer dependence |
| cons_id | input | 4 | Processor that consumed this core's data |
| cons_old | input | 1 | Dependence concerns delayed data of the retired interval |
| wr_vld | input | 1 | Write or exclusive read performed |
| wr_addr | input | 32 | Line address to insert |
| q_addr | input | 32 | Line address to test |
| q_old | input | 1 | Test the retired bank instead of the active one |
| q_hit | output | 1 | Signature membership result |
| ckpt | input | 1 | Checkpoint command |
| wb_done | input | 1 | Delayed writebacks finished |
| rollback | input | 1 | Rollback command |
| rd_sel | input | 1 | Absolute bank index for the read port |
| rd_prod | output | 16 | Producer bitmap of bank `rd_sel` |
| rd_cons | output | 16 | Consumer bitmap of bank `rd_sel` |
| active_set | output | 1 | Index of the recording bank |
| draining | output | 1 | Retired bank still holds an interval |

## Verification
The bench goes after the same-cycle collisions. One is an update arriving with an accepted checkpoint: a design that routed it by the new pointer would put it in the wrong bank. Another is `wb_done` together with `ckpt`: a design that ignored the order would refuse the checkpoint or clear the new bank. A third is `rollback` with updates: a design that let updates win would leave stale bits after recovery. It also checks that a second checkpoint during draining is ignored, since a design that toggled anyway would drop the retired interval. Old-interval updates while nothing is draining must vanish, and signature queries are checked against an independently computed Bloom membership, so a wrong hash or a false negative shows up as a hit mismatch.

// File: rtl/dep_pkg.sv
package dep_pkg;
    localparam int NPROC_DEF    = 16;
    localparam int SIG_BITS_DEF = 512;
    localparam int ADDR_W_DEF   = 32;

    typedef struct packed {
        logic act;
        logic drain;
    } ctl_t;
endpackage

// File: rtl/dep_sig_hash.sv
module dep_sig_hash #(
    parameter int ADDR_W = 32,
    parameter int SIDX   = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SIDX-1:0]   h0,
    output logic [SIDX-1:0]   h1
);
    localparam int NCHUNK = (ADDR_W + SIDX - 1) / SIDX;

    logic [NCHUNK*SIDX-1:0] pad;
    logic [SIDX-1:0]        chunk;
    logic [SIDX-1:0]        rot;

    always_comb begin
        pad = '0;
        pad[ADDR_W-1:0] = addr;
        h0 = '0;
        h1 = '0;
        chunk = '0;
        rot = '0;
        for (int k = 0; k < NCHUNK; k++) begin
            chunk = pad[k*SIDX +: SIDX];
            h0 = h0 ^ chunk;
            for (int i = 0; i < SIDX; i++) begin
                rot[(i + 2*k + 1) % SIDX] = chunk[i];
            end
            h1 = h1 ^ rot;
        end
    end
endmodule

// File: rtl/dep_bank.sv
module dep_bank #(
    parameter int NPROC    = 16,
    parameter int SIG_BITS = 512,
    parameter int SIDX     = $clog2(SIG_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [NPROC-1:0] prod_set,
    input  logic [NPROC-1:0] cons_set,
    input  logic             ins_vld,
    input  logic [SIDX-1:0]  ins_h0,
    input  logic [SIDX-1:0]  ins_h1,
    input  logic [SIDX-1:0]  qry_h0,
    input  logic [SIDX-1:0]  qry_h1,
    output logic             qry_hit,
    output logic [NPROC-1:0] prod_o,
    output logic [NPROC-1:0] cons_o,
    output logic             empty_o
);
    typedef struct packed {
        logic [NPROC-1:0]    prod;
        logic [NPROC-1:0]    cons;
        logic [SIG_BITS-1:0] sig;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.prod = st_q.prod | prod_set;
            st_d.cons = st_q.cons | cons_set;
            if (ins_vld) begin
                st_d.sig[ins_h0] = 1'b1;
                st_d.sig[ins_h1] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qry_hit = st_q.sig[qry_h0] & st_q.sig[qry_h1];
    assign prod_o  = st_q.prod;
    assign cons_o  = st_q.cons;
    assign empty_o = (st_q == '0);

    // R4: without a clear no recorded bit ever drops
    a_r4_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((st_q & $past(st_q)) == $past(st_q)));

    // R5: an inserted address is a member from the next cycle on
    a_r5_no_false_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_vld && !clr) |=> (st_q.sig[$past(ins_h0)] && st_q.sig[$past(ins_h1)]));
endmodule

// File: rtl/dep_reg_unit.sv
module dep_reg_unit
    import dep_pkg::*;
#(
    parameter int NPROC    = NPROC_DEF,
    parameter int SIG_BITS = SIG_BITS_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    localparam int PID_W   = $clog2(NPROC),
    localparam int SIDX    = $clog2(SIG_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_vld,
    input  logic [PID_W-1:0]  prod_id,
    input  logic              prod_old,
    input  logic              cons_vld,
    input  logic [PID_W-1:0]  cons_id,
    input  logic              cons_old,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic              q_old,
    output logic              q_hit,
    input  logic              ckpt,
    input  logic              wb_done,
    input  logic              rollback,
    input  logic              rd_sel,
    output logic [NPROC-1:0]  rd_prod,
    output logic [NPROC-1:0]  rd_cons,
    output logic              active_set,
    output logic              draining
);
    localparam int NBANK = 2;

    ctl_t ctl_d, ctl_q;

    logic [SIDX-1:0]  wr_h0, wr_h1, q_h0, q_h1;
    logic [NPROC-1:0] prod_vec, cons_vec;
    logic [NPROC-1:0] prod_w  [NBANK];
    logic [NPROC-1:0] cons_w  [NBANK];
    logic             hit_w   [NBANK];
    logic             empty_w [NBANK];

    dep_sig_hash #(.ADDR_W(ADDR_W), .SIDX(SIDX)) wr_hash_i (
        .addr(wr_addr), .h0(wr_h0), .h1(wr_h1));
    dep_sig_hash #(.ADDR_W(ADDR_W), .SIDX(SIDX)) q_hash_i (
        .addr(q_addr), .h0(q_h0), .h1(q_h1));

    assign prod_vec = NPROC'(1) << prod_id;
    assign cons_vec = NPROC'(1) << cons_id;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic             is_act, is_ret, clr_b, ins_b;
        logic [NPROC-1:0] pset_b, cset_b;

        assign is_act = (ctl_q.act == 1'(b));
        assign is_ret = ctl_q.drain & ~is_act;
        assign clr_b  = rollback | (wb_done & is_ret);
        assign pset_b = (prod_vld && !rollback && (prod_old ? is_ret : is_act)) ? prod_vec : '0;
        assign cset_b = (cons_vld && !rollback && (cons_old ? is_ret : is_act)) ? cons_vec : '0;
        assign ins_b  = wr_vld & ~rollback & is_act;

        dep_bank #(.NPROC(NPROC), .SIG_BITS(SIG_BITS), .SIDX(SIDX)) bank_i (
            .clk(clk), .rst_n(rst_n), .clr(clr_b),
            .prod_set(pset_b), .cons_set(cset_b),
            .ins_vld(ins_b), .ins_h0(wr_h0), .ins_h1(wr_h1),
            .qry_h0(q_h0), .qry_h1(q_h1), .qry_hit(hit_w[b]),
            .prod_o(prod_w[b]), .cons_o(cons_w[b]), .empty_o(empty_w[b]));
    end

    always_comb begin
        ctl_d = ctl_q;
        if (rollback) begin
            ctl_d.drain = 1'b0;
        end else begin
            if (wb_done) ctl_d.drain = 1'b0;
            if (ckpt && !ctl_d.drain) begin
                ctl_d.act   = ~ctl_q.act;
                ctl_d.drain = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign q_hit      = hit_w[q_old ? ~ctl_q.act : ctl_q.act];
    assign rd_prod    = prod_w[rd_sel];
    assign rd_cons    = cons_w[rd_sel];
    assign active_set = ctl_q.act;
    assign draining   = ctl_q.drain;

    // R6: when nothing drains, the idle bank is fully clean
    a_r6_idle_bank_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.drain |-> empty_w[~ctl_q.act]);

    // R6: a checkpoint during draining leaves the pointer alone
    a_r6_ignored_ckpt: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt && draining && !wb_done && !rollback) |=> $stable(active_set));

    // R7: writeback completion ends draining unless a new checkpoint starts
    a_r7_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_done && !ckpt && !rollback) |=> !draining);

    // R8: rollback empties both banks
    a_r8_rollback_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> (empty_w[0] && empty_w[1] && !draining));
endmodule

// File: tb/dep_reg_unit_tb_top.sv
`timescale 1ns/1ps
module dep_reg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prod_vld = 0, prod_old = 0, cons_vld = 0, cons_old = 0;
    logic [3:0]  prod_id = 0, cons_id = 0;
    logic        wr_vld = 0, q_old = 0, ckpt = 0, wb_done = 0, rollback = 0, rd_sel = 0;
    logic [31:0] wr_addr = 0, q_addr = 0;
    logic        q_hit, active_set, draining;
    logic [15:0] rd_prod, rd_cons;

    always #2.5 clk = ~clk;

    dep_reg_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .prod_vld(prod_vld), .prod_id(prod_id), .prod_old(prod_old),
        .cons_vld(cons_vld), .cons_id(cons_id), .cons_old(cons_old),
        .wr_vld(wr_vld), .wr_addr(wr_addr), .q_addr(q_addr), .q_old(q_old),
        .q_hit(q_hit), .ckpt(ckpt), .wb_done(wb_done), .rollback(rollback),
        .rd_sel(rd_sel), .rd_prod(rd_prod), .rd_cons(rd_cons),
        .active_set(active_set), .draining(draining));

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    // behavioural model
    bit          m_act, m_drain;
    bit [15:0]   m_prod [2];
    bit [15:0]   m_cons [2];
    logic [31:0] m_wr0[$];
    logic [31:0] m_wr1[$];

    function automatic int hidx(input logic [31:0] a, input int which);
        logic [35:0] p;
        int acc;
        int c;
        p = {4'b0, a};
        acc = 0;
        for (int k = 0; k < 4; k++) begin
            c = int'(p[k*9 +: 9]);
            if (which == 1) begin
                int r;
                r = (2*k + 1) % 9;
                c = ((c << r) | (c >> (9 - r))) & 511;
            end
            acc = acc ^ c;
        end
        return acc;
    endfunction

    function automatic bit member(input bit bank, input logic [31:0] a);
        bit f0, f1;
        int i0, i1;
        logic [31:0] lst[$];
        lst = bank ? m_wr1 : m_wr0;
        i0 = hidx(a, 0);
        i1 = hidx(a, 1);
        f0 = 0; f1 = 0;
        foreach (lst[j]) begin
            if (hidx(lst[j], 0) == i0 || hidx(lst[j], 1) == i0) f0 = 1;
            if (hidx(lst[j], 0) == i1 || hidx(lst[j], 1) == i1) f1 = 1;
        end
        return f0 && f1;
    endfunction

    task automatic clear_bank(input bit b);
        m_prod[b] = 0;
        m_cons[b] = 0;
        if (b) m_wr1.delete(); else m_wr0.delete();
    endtask

    task automatic cmp(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_step();
        bit ret;
        if (rollback) begin
            clear_bank(0); clear_bank(1);
            m_drain = 0;
            return;
        end
        ret = ~m_act;
        if (prod_vld) begin
            if (!prod_old) m_prod[m_act][prod_id] = 1;
            else if (m_drain) m_prod[ret][prod_id] = 1;
        end
        if (cons_vld) begin
            if (!cons_old) m_cons[m_act][cons_id] = 1;
            else if (m_drain) m_cons[ret][cons_id] = 1;
        end
        if (wr_vld) begin
            if (m_act) m_wr1.push_back(wr_addr); else m_wr0.push_back(wr_addr);
        end
        if (wb_done && m_drain) begin
            clear_bank(ret);
            m_drain = 0;
        end
        if (ckpt && !m_drain) begin
            m_act = ~m_act;
            m_drain = 1;
        end
    endtask

    // called at a negedge with inputs set; compares, advances, clears strobes
    task automatic tick();
        #1;
        cmp("active_set", {31'b0, active_set}, {31'b0, m_act});
        cmp("draining",   {31'b0, draining},   {31'b0, m_drain});
        cmp("rd_prod",    {16'b0, rd_prod},    {16'b0, m_prod[rd_sel]});
        cmp("rd_cons",    {16'b0, rd_cons},    {16'b0, m_cons[rd_sel]});
        cmp("q_hit",      {31'b0, q_hit},      {31'b0, member(q_old ? ~m_act : m_act, q_addr)});
        @(posedge clk);
        model_step();
        @(negedge clk);
        prod_vld = 0; cons_vld = 0; wr_vld = 0;
        ckpt = 0; wb_done = 0; rollback = 0;
    endtask

    task automatic do_prod(input int id, input bit old);
        prod_vld = 1; prod_id = 4'(id); prod_old = old; tick();
    endtask

    task automatic do_cons(input int id, input bit old);
        cons_vld = 1; cons_id = 4'(id); cons_old = old; tick();
    endtask

    task automatic do_wr(input logic [31:0] a);
        wr_vld = 1; wr_addr = a; tick();
    endtask

    task automatic do_q(input logic [31:0] a, input bit old);
        q_addr = a; q_old = old; tick();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        m_act = 0; m_drain = 0;
        clear_bank(0); clear_bank(1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state on both banks
        tag = "R1";
        rd_sel = 0; do_q(32'h0000_1000, 0);
        rd_sel = 1; do_q(32'h0000_1000, 1);
        rd_sel = 0;

        // R2: producer updates, old-interval update dropped while idle
        tag = "R2";
        do_prod(3, 0); do_prod(15, 0); do_prod(0, 0); do_prod(9, 1);
        tick();
        // R3: consumer updates
        tag = "R3";
        do_cons(7, 0); do_cons(15, 0); do_cons(2, 1);
        rd_sel = 1; tick(); rd_sel = 0;
        // R4: repeats accumulate and nothing drops
        tag = "R4";
        do_prod(3, 0); do_cons(7, 0); tick();

        // R5: signature inserts and queries
        tag = "R5";
        do_q(32'h0000_1000, 0);
        do_wr(32'h0000_1000); do_wr(32'hdead_beef);
        do_q(32'h0000_1000, 0); do_q(32'hdead_beef, 0);
        do_q(32'h1234_5678, 0); do_q(32'h0000_1000, 1);

        // R6: checkpoint rotates banks, retired keeps contents
        tag = "R6";
        ckpt = 1; tick();
        rd_sel = 0; do_q(32'h0000_1000, 1);
        rd_sel = 1; do_q(32'h0000_1000, 0);
        do_prod(5, 0); do_prod(6, 1); do_cons(12, 1);
        rd_sel = 0; tick();
        ckpt = 1; tick();          // ignored while draining
        rd_sel = 1; do_q(32'hdead_beef, 1);

        // R7: writeback completion clears the retired bank
        tag = "R7";
        wb_done = 1; prod_vld = 1; prod_id = 4'd8; prod_old = 1; tick();
        rd_sel = 0; do_q(32'hdead_beef, 1);
        rd_sel = 1; tick();

        // R10: update and insert together with an accepted checkpoint
        tag = "R10";
        ckpt = 1; prod_vld = 1; prod_id = 4'd11; prod_old = 0;
        wr_vld = 1; wr_addr = 32'h0badf00d; tick();
        rd_sel = 1; do_q(32'h0badf00d, 1);
        rd_sel = 0; do_q(32'h0badf00d, 0);
        // R6: wb_done and ckpt in one cycle: checkpoint accepted
        tag = "R6";
        wb_done = 1; ckpt = 1; cons_vld = 1; cons_id = 4'd4; cons_old = 0; tick();
        rd_sel = 1; tick(); rd_sel = 0; tick();

        // R8: rollback beats everything in its cycle
        tag = "R8";
        do_wr(32'h0000_2222);
        rollback = 1; ckpt = 1; prod_vld = 1; prod_id = 4'd1; prod_old = 0;
        wr_vld = 1; wr_addr = 32'h0000_3333; tick();
        rd_sel = 0; do_q(32'h0000_2222, 0);
        rd_sel = 1; do_q(32'h0000_3333, 1);

        // R9: random traffic with the read port wandering over both banks
        tag = "R9";
        for (int n = 0; n < 4000; n++) begin
            prod_vld = ($urandom_range(0, 3) == 0);
            prod_id  = 4'($urandom_range(0, 15));
            prod_old = $urandom_range(0, 1) == 1;
            cons_vld = ($urandom_range(0, 3) == 0);
            cons_id  = 4'($urandom_range(0, 15));
            cons_old = $urandom_range(0, 1) == 1;
            wr_vld   = ($urandom_range(0, 5) == 0);
            wr_addr  = $urandom();
            q_addr   = ($urandom_range(0, 1) == 1 && m_wr0.size() > 0) ? m_wr0[0] : $urandom();
            q_old    = $urandom_range(0, 1) == 1;
            ckpt     = ($urandom_range(0, 15) == 0);
            wb_done  = ($urandom_range(0, 11) == 0);
            rollback = ($urandom_range(0, 199) == 0);
            rd_sel   = $urandom_range(0, 1) == 1;
            tick();
        end

        summary();
        $finish;
    end
endmodule